// File: doc/BRIEF.md
# Serial Command Decoder with Channel Broadcast

This block sits behind the byte-level receiver of a serial control port on an eight-channel device. It takes the bytes of one command from a byte stream, split into commands by a frame signal. It turns them into accesses on a generic write port and a generic read port. Behind those ports sit per-channel local registers, shared global registers, a per-channel coefficient RAM and a tone-generator RAM. The first byte of a frame is a command byte. It carries the direction, the target type and a start address. The bytes after it are data bytes for a write, or dummy bytes for a read. Each dummy byte asks for one reply byte.

A write to a local register or a RAM reaches every channel whose bit is set in an eight-bit channel-enable input. With several bits set, one command writes the same data to several channels at once. Reads never broadcast. A local or RAM read takes its data from the lowest-numbered enabled channel. Every read reply starts with a fixed identification byte. The data bytes follow it.

A command that cannot be served puts the parser into an error state, and the parser then ignores the rest of the frame.

Top module: `serial_cmd_decoder`

## Requirements
- R1: Bit 7 of the command byte selects the direction: 1 for write, 0 for read. Bits 6:5 select the target: 00 local register, 01 global register, 11 RAM. For RAM, bit 4 picks the coefficient RAM (0) or the tone RAM (1). The wr_tgt and rd_tgt outputs encode the target as 0 local, 1 global, 2 coefficient RAM, 3 tone RAM.
- R2: A command byte whose bits 6:5 are 10 raises err in the cycle after it is accepted. While err is high, no write strobe, read request or output byte is produced.
- R3: The following command bytes also raise err:
  - a local address of 12 or more;
  - a global address of 26 or more;
  - a coefficient block (bits 3:0) of 5 or more;
  - a tone RAM command with bit 3 set, or with a block (bits 2:0) of 4 or more;
  - a local or RAM command while chan_en is all zero.
- R4: Each data byte of a register write produces one wr_en pulse in the cycle after the byte is accepted. The pulse carries address start+k for the k-th data byte and wr_data = {8'h00, byte}. At most 4 data bytes are used. Bytes beyond the fourth, and bytes whose address would pass the last register, cause no write.
- R5: RAM writes pair the data bytes, high byte first. Each pair writes one 16-bit word at word address block*8 + k. The pulse comes in the cycle after the low byte is accepted. At most 16 data bytes (8 words) are used, and later bytes are ignored.
- R6: Local and RAM writes carry wr_mask equal to chan_en as it stood when the command byte was accepted. Global writes carry an all-zero wr_mask.
- R7: After a read command is accepted, out_valid pulses with out_data = 8'h81 in the next cycle. Each further accepted input byte that lies within the same limits as R4 and R5 produces one output byte in the cycle after it is accepted.
- R8: Local and RAM reads present on rd_chan the lowest-numbered channel whose chan_en bit is set. Global reads present rd_chan = 0. Register reads reply with rd_data[7:0].
- R9: RAM reads issue one rd_req per word, on the even byte. They reply with rd_data[15:8] first and then rd_data[7:0].
- R10: When frame_i is low at a clock edge, the parser returns to waiting for a command byte and err clears. The first byte accepted in the next frame is decoded as a command.
- R11: in_ready equals frame_i. Bytes offered while frame_i is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | High for the duration of one command |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser accepts a byte |
| chan_en | input | NCH | Channel-enable mask from the global register |
| wr_en | output | 1 | Write strobe, one cycle |
| wr_tgt | output | 2 | Write target (0 local, 1 global, 2 coefficient, 3 tone) |
| wr_mask | output | NCH | Channels receiving the write |
| wr_addr | output | AW | Register address or RAM word address |
| wr_data | output | 16 | Write data (register writes use the low byte) |
| rd_req | output | 1 | Read request; rd_data is sampled in the same cycle |
| rd_tgt | output | 2 | Read target, same encoding as wr_tgt |
| rd_chan | output | CW | Channel to read from |
| rd_addr | output | AW | Register address or RAM word address |
| rd_data | input | 16 | Read data returned in the request cycle |
| out_valid | output | 1 | Reply byte valid |
| out_data | output | 8 | Reply byte |
| err | output | 1 | Current command rejected |

## Verification
The bench uses the default parameters: eight channels, 12 local and 26 global registers, five coefficient blocks and four tone blocks of eight words, and caps of 4 and 16 bytes. With these values it can send every illegal block and address just past each legal range, and it can stop a global write at the last register, address 25. The eight-bit mask lets it try a sparse broadcast pattern and a lowest-channel pick from the middle of the mask. It also covers the 4-byte and 16-byte caps with commands that send more bytes than the cap.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  typedef enum logic [1:0] {
    TGT_LOCAL  = 2'd0,
    TGT_GLOBAL = 2'd1,
    TGT_COEF   = 2'd2,
    TGT_TONE   = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_DATA = 2'd1,
    ST_DROP = 2'd2
  } pstate_e;
endpackage

// File: rtl/ccd_cmd_decode.sv
module ccd_cmd_decode
  import ccd_pkg::*;
#(
  parameter int NLOC  = 12,
  parameter int NGLB  = 26,
  parameter int NCBLK = 5,
  parameter int NTBLK = 4,
  parameter int WPB   = 8,
  parameter int AW    = 6
) (
  input  logic [7:0]    cmd,
  input  logic          mask_any,
  output logic          is_wr,
  output tgt_e          tgt,
  output logic [AW-1:0] base,
  output logic          legal
);
  localparam int WPB_W = $clog2(WPB);

  always_comb begin
    is_wr = cmd[7];
    tgt   = TGT_LOCAL;
    base  = '0;
    legal = 1'b0;
    case (cmd[6:5])
      2'b00: begin
        tgt   = TGT_LOCAL;
        base  = AW'(cmd[4:0]);
        legal = (32'(cmd[4:0]) < NLOC) && mask_any;
      end
      2'b01: begin
        tgt   = TGT_GLOBAL;
        base  = AW'(cmd[4:0]);
        legal = 32'(cmd[4:0]) < NGLB;
      end
      2'b11: begin
        if (!cmd[4]) begin
          tgt   = TGT_COEF;
          base  = AW'(cmd[3:0]) << WPB_W;
          legal = (32'(cmd[3:0]) < NCBLK) && mask_any;
        end else begin
          tgt   = TGT_TONE;
          base  = AW'(cmd[2:0]) << WPB_W;
          legal = !cmd[3] && (32'(cmd[2:0]) < NTBLK) && mask_any;
        end
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccd_low_chan.sv
module ccd_low_chan #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic [NCH-1:0] en,
  output logic [CW-1:0]  idx,
  output logic           any
);
  logic [NCH:0]   seen;
  logic [NCH-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign seen[i+1] = seen[i] | en[i];
    assign first[i]  = en[i] & ~seen[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (first[i]) idx = idx | CW'(i);
    end
  end

  assign any = seen[NCH];
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import ccd_pkg::*;
#(
  parameter int         NCH       = 8,
  parameter int         NLOC      = 12,
  parameter int         NGLB      = 26,
  parameter int         NCBLK     = 5,
  parameter int         NTBLK     = 4,
  parameter int         WPB       = 8,
  parameter int         REG_BYTES = 4,
  parameter int         RAM_BYTES = 16,
  parameter logic [7:0] ID_CODE   = 8'h81,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MAXB  = (NCBLK > NTBLK) ? NCBLK : NTBLK,
  localparam int MAXR  = (NGLB > NLOC) ? NGLB : NLOC,
  localparam int MAXA  = (MAXB * WPB > MAXR) ? MAXB * WPB : MAXR,
  localparam int AW    = $clog2(MAXA),
  localparam int CNT_W = $clog2(RAM_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_i,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  output logic           in_ready,
  input  logic [NCH-1:0] chan_en,
  output logic           wr_en,
  output logic [1:0]     wr_tgt,
  output logic [NCH-1:0] wr_mask,
  output logic [AW-1:0]  wr_addr,
  output logic [15:0]    wr_data,
  output logic           rd_req,
  output logic [1:0]     rd_tgt,
  output logic [CW-1:0]  rd_chan,
  output logic [AW-1:0]  rd_addr,
  input  logic [15:0]    rd_data,
  output logic           out_valid,
  output logic [7:0]     out_data,
  output logic           err
);
  // decode of the incoming byte as a command
  logic          dec_wr, dec_legal, mask_any;
  tgt_e          dec_tgt;
  logic [AW-1:0] dec_base;
  logic [CW-1:0] low_idx;

  ccd_cmd_decode #(.NLOC(NLOC), .NGLB(NGLB), .NCBLK(NCBLK), .NTBLK(NTBLK),
                   .WPB(WPB), .AW(AW)) u_dec (
    .cmd(in_data), .mask_any(mask_any), .is_wr(dec_wr), .tgt(dec_tgt),
    .base(dec_base), .legal(dec_legal));

  ccd_low_chan #(.NCH(NCH), .CW(CW)) u_low (
    .en(chan_en), .idx(low_idx), .any(mask_any));

  // command context and output registers
  pstate_e        st_q, st_n;
  logic           wr_q, wr_n;
  tgt_e           tgt_q, tgt_n;
  logic [AW-1:0]  base_q, base_n;
  logic [NCH-1:0] mask_q, mask_n;
  logic [CW-1:0]  chan_q, chan_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]     hold_q, hold_n;
  logic           wen_q, wen_n;
  logic [1:0]     wtgt_q, wtgt_n;
  logic [NCH-1:0] wmask_q, wmask_n;
  logic [AW-1:0]  waddr_q, waddr_n;
  logic [15:0]    wdata_q, wdata_n;
  logic           ov_q, ov_n;
  logic [7:0]     od_q, od_n;

  logic             acc, is_ram, odd, in_win;
  logic [CNT_W-1:0] byte_lim;
  logic [AW-1:0]    reg_addr, word_addr;

  assign acc       = in_valid & frame_i;
  assign is_ram    = tgt_q[1];
  assign odd       = cnt_q[0];
  assign byte_lim  = is_ram ? CNT_W'(RAM_BYTES) : CNT_W'(REG_BYTES);
  assign reg_addr  = base_q + AW'(cnt_q);
  assign word_addr = base_q + AW'(cnt_q >> 1);
  assign in_win    = (cnt_q < byte_lim) &&
                     (is_ram || (32'(reg_addr) < ((tgt_q == TGT_GLOBAL) ? NGLB : NLOC)));

  assign rd_req  = acc && (st_q == ST_DATA) && in_win && !wr_q && (!is_ram || !odd);
  assign rd_addr = is_ram ? word_addr : reg_addr;
  assign rd_tgt  = tgt_q;
  assign rd_chan = chan_q;

  always_comb begin
    st_n = st_q;   wr_n = wr_q;   tgt_n = tgt_q;   base_n = base_q;
    mask_n = mask_q; chan_n = chan_q; cnt_n = cnt_q; hold_n = hold_q;
    wen_n = 1'b0;  wtgt_n = wtgt_q; wmask_n = wmask_q;
    waddr_n = waddr_q; wdata_n = wdata_q;
    ov_n = 1'b0;   od_n = od_q;
    if (!frame_i) begin
      st_n  = ST_CMD;
      cnt_n = '0;
    end else if (acc) begin
      case (st_q)
        ST_CMD: begin
          wr_n   = dec_wr;
          tgt_n  = dec_tgt;
          base_n = dec_base;
          mask_n = (dec_tgt == TGT_GLOBAL) ? '0 : chan_en;
          chan_n = (dec_tgt == TGT_GLOBAL) ? '0 : low_idx;
          cnt_n  = '0;
          st_n   = dec_legal ? ST_DATA : ST_DROP;
          if (dec_legal && !dec_wr) begin
            ov_n = 1'b1;
            od_n = ID_CODE;
          end
        end
        ST_DATA: begin
          if (in_win) begin
            cnt_n = cnt_q + 1'b1;
            if (wr_q) begin
              if (is_ram && !odd) begin
                hold_n = in_data;
              end else begin
                wen_n   = 1'b1;
                wtgt_n  = tgt_q;
                wmask_n = mask_q;
                waddr_n = is_ram ? word_addr : reg_addr;
                wdata_n = is_ram ? {hold_q, in_data} : {8'h00, in_data};
              end
            end else begin
              ov_n = 1'b1;
              if (!is_ram) begin
                od_n = rd_data[7:0];
              end else if (!odd) begin
                od_n   = rd_data[15:8];
                hold_n = rd_data[7:0];
              end else begin
                od_n = hold_q;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_CMD;  wr_q <= 1'b0;  tgt_q <= TGT_LOCAL;  base_q <= '0;
      mask_q <= '0;  chan_q <= '0;  cnt_q <= '0;  hold_q <= '0;
      wen_q <= 1'b0; wtgt_q <= '0;  wmask_q <= '0; waddr_q <= '0; wdata_q <= '0;
      ov_q <= 1'b0;  od_q <= '0;
    end else begin
      st_q <= st_n;  wr_q <= wr_n;  tgt_q <= tgt_n;  base_q <= base_n;
      mask_q <= mask_n;  chan_q <= chan_n;  cnt_q <= cnt_n;  hold_q <= hold_n;
      wen_q <= wen_n; wtgt_q <= wtgt_n; wmask_q <= wmask_n; waddr_q <= waddr_n;
      wdata_q <= wdata_n;
      ov_q <= ov_n;  od_q <= od_n;
    end
  end

  assign in_ready  = frame_i;
  assign wr_en     = wen_q;
  assign wr_tgt    = wtgt_q;
  assign wr_mask   = wmask_q;
  assign wr_addr   = waddr_q;
  assign wr_data   = wdata_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign err       = (st_q == ST_DROP);
endmodule

// File: rtl/ccd_checker.sv
module ccd_checker #(
  parameter int NCH  = 8,
  parameter int NLOC = 12,
  parameter int AW   = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_i,
  input logic           in_valid,
  input logic           err,
  input logic           wr_en,
  input logic [1:0]     wr_tgt,
  input logic [NCH-1:0] wr_mask,
  input logic [AW-1:0]  wr_addr,
  input logic           rd_req,
  input logic           out_valid
);
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_en && !out_valid && !rd_req)); // R2

  AST_FRAME_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> !err); // R10

  AST_LOCAL_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tgt == 2'd0) |-> (32'(wr_addr) < NLOC)); // R4

  AST_BCAST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tgt != 2'd1) |-> (wr_mask != '0)); // R6

  AST_GLOBAL_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tgt == 2'd1) |-> (wr_mask == '0)); // R6

  AST_READ_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (frame_i && in_valid)); // R7
endmodule

bind serial_cmd_decoder ccd_checker #(.NCH(NCH), .NLOC(NLOC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .in_valid(in_valid), .err(err),
  .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_mask(wr_mask), .wr_addr(wr_addr),
  .rd_req(rd_req), .out_valid(out_valid));

// File: tb/serial_cmd_decoder_test.sv
module serial_cmd_decoder_test;
  logic        clk, rst_n, frame_i, in_valid, in_ready;
  logic [7:0]  in_data, out_data;
  logic [7:0]  chan_en, wr_mask;
  logic        wr_en, rd_req, out_valid, err;
  logic [1:0]  wr_tgt, rd_tgt;
  logic [5:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [2:0]  rd_chan;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] wq[$];
  logic [7:0]  oq[$];

  serial_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .chan_en(chan_en),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_mask(wr_mask), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_tgt(rd_tgt), .rd_chan(rd_chan),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid),
    .out_data(out_data), .err(err));

  // storage model: high byte {target, address}, low byte {channel, address[4:0]}
  assign rd_data = {rd_tgt, rd_addr, rd_chan, rd_addr[4:0]};

  function automatic logic [7:0] hi_of(input logic [1:0] t, input logic [5:0] a);
    return {t, a};
  endfunction
  function automatic logic [7:0] lo_of(input logic [2:0] c, input logic [5:0] a);
    return {c, a[4:0]};
  endfunction

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (wr_en) wq.push_back({wr_tgt, wr_mask, wr_addr, wr_data});
    if (out_valid) oq.push_back(out_data);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic open_frame(input logic [7:0] mask);
    @(negedge clk);
    wq.delete();
    oq.delete();
    chan_en = mask;
    frame_i = 1'b1;
  endtask

  task automatic close_frame();
    repeat (2) @(negedge clk);
    frame_i = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic exp_wr(input string tag, input int i, input logic [1:0] t,
                        input logic [7:0] m, input logic [5:0] a, input logic [15:0] d);
    if (i < wq.size()) chk(tag, wq[i], {t, m, a, d});
    else chk({tag, " missing write"}, 32'(wq.size()), 32'(i + 1));
  endtask

  task automatic exp_out(input string tag, input int i, input logic [7:0] b);
    if (i < oq.size()) chk(tag, 32'(oq[i]), 32'(b));
    else chk({tag, " missing byte"}, 32'(oq.size()), 32'(i + 1));
  endtask

  task automatic t_reset();
    chk("R11 in_ready low out of frame", 32'(in_ready), 0);
    chk("R2 err after reset", 32'(err), 0);
    chk("R4 wr_en after reset", 32'(wr_en), 0);
    chk("R7 out_valid after reset", 32'(out_valid), 0);
  endtask

  task automatic t_local_bcast();
    open_frame(8'hA5);
    #1 chk("R11 in_ready in frame", 32'(in_ready), 1);
    send(8'h82); send(8'h11); send(8'h22); send(8'h33);
    close_frame();
    chk("R1 R4 local write count", 32'(wq.size()), 3);
    exp_wr("R6 local bcast 0", 0, 2'd0, 8'hA5, 6'd2, 16'h0011);
    exp_wr("R4 local bcast 1", 1, 2'd0, 8'hA5, 6'd3, 16'h0022);
    exp_wr("R4 local bcast 2", 2, 2'd0, 8'hA5, 6'd4, 16'h0033);
  endtask

  task automatic t_reg_cap();
    open_frame(8'h01);
    send(8'h80);
    for (int i = 1; i <= 6; i++) send(8'(i));
    close_frame();
    chk("R4 four-byte cap", 32'(wq.size()), 4);
    exp_wr("R4 cap last", 3, 2'd0, 8'h01, 6'd3, 16'h0004);
  endtask

  task automatic t_global_edge();
    open_frame(8'hFF);
    send(8'hB8); send(8'h07); send(8'h08); send(8'h09);
    close_frame();
    chk("R4 global stops at last reg", 32'(wq.size()), 2);
    exp_wr("R6 global no mask 0", 0, 2'd1, 8'h00, 6'd24, 16'h0007);
    exp_wr("R6 global no mask 1", 1, 2'd1, 8'h00, 6'd25, 16'h0008);
  endtask

  task automatic t_coef_write();
    open_frame(8'h0C);
    send(8'hE3); send(8'hAA);
    chk("R5 no write after high byte", 32'(wq.size()), 0);
    send(8'hBB); send(8'hCC); send(8'hDD);
    close_frame();
    chk("R5 coef word count", 32'(wq.size()), 2);
    exp_wr("R5 coef word 0", 0, 2'd2, 8'h0C, 6'd24, 16'hAABB);
    exp_wr("R5 coef word 1", 1, 2'd2, 8'h0C, 6'd25, 16'hCCDD);
  endtask

  task automatic t_tone_cap();
    open_frame(8'h80);
    send(8'hF3);
    for (int i = 0; i < 18; i++) send(8'(i));
    close_frame();
    chk("R5 tone 16-byte cap", 32'(wq.size()), 8);
    exp_wr("R5 tone first", 0, 2'd3, 8'h80, 6'd24, 16'h0001);
    exp_wr("R5 tone last", 7, 2'd3, 8'h80, 6'd31, 16'h0E0F);
  endtask

  task automatic t_illegal_type();
    open_frame(8'hFF);
    send(8'hC0);
    chk("R2 err on type 10", 32'(err), 1);
    send(8'h05); send(8'h06);
    chk("R2 err holds", 32'(err), 1);
    close_frame();
    chk("R2 no writes", 32'(wq.size()), 0);
    chk("R2 no output", 32'(oq.size()), 0);
    chk("R10 err clears", 32'(err), 0);
    open_frame(8'h02);
    send(8'h81); send(8'h5A);
    close_frame();
    chk("R10 new command after frame", 32'(wq.size()), 1);
    exp_wr("R10 new command write", 0, 2'd0, 8'h02, 6'd1, 16'h005A);
  endtask

  task automatic t_range();
    logic [7:0] bad [5] = '{8'h8C, 8'hBA, 8'hE5, 8'hF8, 8'hF4};
    for (int i = 0; i < 5; i++) begin
      open_frame(8'hFF);
      send(bad[i]);
      chk($sformatf("R3 err for %h", bad[i]), 32'(err), 1);
      send(8'h01); send(8'h02);
      close_frame();
      chk($sformatf("R3 no write for %h", bad[i]), 32'(wq.size()), 0);
    end
    open_frame(8'h00);
    send(8'h81);
    chk("R3 err on empty mask", 32'(err), 1);
    close_frame();
    open_frame(8'h00);
    send(8'hA1); send(8'h3C);
    close_frame();
    exp_wr("R3 global legal with empty mask", 0, 2'd1, 8'h00, 6'd1, 16'h003C);
  endtask

  task automatic t_local_read();
    open_frame(8'h68);
    send(8'h05);
    chk("R7 id byte next cycle", 32'(oq.size()), 1);
    for (int i = 0; i < 5; i++) send(8'hFF);
    close_frame();
    chk("R7 reply length", 32'(oq.size()), 5);
    exp_out("R7 id code", 0, 8'h81);
    for (int i = 0; i < 4; i++)
      exp_out("R8 lowest channel data", i + 1, lo_of(3'd3, 6'(5 + i)));
    chk("R7 no write on read", 32'(wq.size()), 0);
  endtask

  task automatic t_ram_read();
    open_frame(8'h01);
    send(8'h61);
    for (int i = 0; i < 4; i++) send(8'h00);
    close_frame();
    chk("R9 ram reply length", 32'(oq.size()), 5);
    exp_out("R9 id", 0, 8'h81);
    exp_out("R9 hi 0", 1, hi_of(2'd2, 6'd8));
    exp_out("R9 lo 0", 2, lo_of(3'd0, 6'd8));
    exp_out("R9 hi 1", 3, hi_of(2'd2, 6'd9));
    exp_out("R9 lo 1", 4, lo_of(3'd0, 6'd9));
  endtask

  task automatic t_global_read();
    open_frame(8'h08);
    send(8'h23); send(8'h00);
    close_frame();
    exp_out("R8 global id", 0, 8'h81);
    exp_out("R8 global read ignores mask", 1, lo_of(3'd0, 6'd3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; frame_i = 1'b0; in_valid = 1'b0; in_data = '0; chan_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_local_bcast();
    t_reg_cap();
    t_global_edge();
    t_coef_write();
    t_tone_cap();
    t_illegal_type();
    t_range();
    t_local_read();
    t_ram_read();
    t_global_read();
    summary();
  end
endmodule